// File: doc/BRIEF.md
# Keyed Jump-Control Filter

This block turns the 18-cell state of one jump register into a single jump-control bit. The bit depends on a 16-bit section key. Nine state cells are gathered into a 9-bit vector, and which cells are used depends on the register type. The low key bits are XORed onto the vector. The sum is then substituted through the multiplicative inverse in GF(2^9), and only seven middle bits of that inverse are kept.

Those seven bits are XORed with the upper key bits. The result indexes a balanced, 2-resilient Boolean function of seven variables, whose value is the output bit. A chain of such filters, one per register section, steers how the next section steps.

The inverse is computed by logic. A parameter can insert a pipeline register after the inverse. A valid flag travels alongside each result, so one result can be accepted and one delivered every cycle.

Top module: `keyed_filter`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_jc` is 0.
- R2: Each cycle with `in_valid` high yields exactly one result. Results appear in order, with `out_valid` high exactly LAT = 1 + PIPE cycles after the input was sampled (LAT = 2 by default).
- R3: With `in_type` = 0, vector bits 0..8 are taken from state bits 0, 1, 3, 4, 5, 6, 8, 9, 10 in that order. Bit 0 of the vector is the least significant.
- R4: With `in_type` = 1, vector bits 0..8 are taken from state bits 0, 1, 2, 3, 4, 6, 8, 9, 10 in that order.
- R5: Key bits 8..0 are XORed bitwise onto the vector, key bit 0 onto vector bit 0, to form the substitution input s.
- R6: The substitution computes the inverse of s in GF(2^9) modulo x^9 + x + 1, with 0 mapped to 0. It keeps bits 7..1 of that inverse as a 7-bit value w, where w bit 0 is inverse bit 1.
- R7: Substitution inputs 0, 1 and 2 give w = 0.
- R8: Key bits 15..9 are XORed onto w, key bit 15 onto w bit 6, giving the 7-bit index z.
- R9: `out_jc` = parity(z[3:0] & M[z[6:4]]) XOR (z6 & z5) XOR z4. The masks M[0..7] are 0111, 1011, 1101, 1110, 1111, 1110, 1101, 1011 in binary. This function is balanced and 2-resilient.
- R10: While `out_valid` is low, `out_jc` keeps its previous value.
- R11: State bits 7 and 11..17 have no effect on the result for either type. Bit 2 has none for type 0, and bit 5 has none for type 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample is present this cycle |
| in_state | input | 18 | Jump register state, bit 0 = first cell |
| in_key | input | 16 | Section key |
| in_type | input | 1 | Register type select (0 or 1) |
| out_valid | output | 1 | `out_jc` carries a new result |
| out_jc | output | 1 | Filter result (jump-control bit) |

## Verification
Every result is due exactly LAT cycles after the clock edge that samples its input. With the default single inner pipeline stage, that is two edges later.

The driver stamps each expected bit with the bench cycle count at which it must appear. The monitor reads outputs on the falling edge and compares both the bit and the arrival cycle. This catches a missing, extra or mistimed result as well as a wrong value.

Idle cycles between inputs let the monitor confirm that `out_jc` holds its value while no result is due.

// File: rtl/kf_pkg.sv
package kf_pkg;

  localparam int unsigned STATE_W = 18;
  localparam int unsigned KEY_W   = 16;
  localparam int unsigned SEL_W   = 9;
  localparam int unsigned SUB_W   = 7;
  localparam int unsigned TBL_N   = 1 << SUB_W;

  // x^9 + x + 1
  localparam logic [SEL_W:0] FIELD_POLY = 10'b10_0000_0011;

  // state bit index feeding each vector bit, vector bit 0 first
  localparam int unsigned CELL_MAP_A [0:SEL_W-1] = '{0, 1, 3, 4, 5, 6, 8, 9, 10};
  localparam int unsigned CELL_MAP_B [0:SEL_W-1] = '{0, 1, 2, 3, 4, 6, 8, 9, 10};

  typedef enum logic {
    REG_KIND_A = 1'b0,
    REG_KIND_B = 1'b1
  } reg_kind_e;

  function automatic logic [SEL_W-1:0] gf_mul(input logic [SEL_W-1:0] a,
                                              input logic [SEL_W-1:0] b);
    logic [2*SEL_W-2:0] prod;
    prod = '0;
    for (int i = 0; i < SEL_W; i++) begin
      if (b[i]) prod = prod ^ ((2*SEL_W-1)'(a) << i);
    end
    for (int i = 2*SEL_W-2; i >= SEL_W; i--) begin
      if (prod[i]) prod = prod ^ ((2*SEL_W-1)'(FIELD_POLY) << (i - SEL_W));
    end
    return prod[SEL_W-1:0];
  endfunction

  function automatic logic [3:0] lin_mask(input logic [2:0] sel);
    case (sel)
      3'd0:    return 4'b0111;
      3'd1:    return 4'b1011;
      3'd2:    return 4'b1101;
      3'd3:    return 4'b1110;
      3'd4:    return 4'b1111;
      3'd5:    return 4'b1110;
      3'd6:    return 4'b1101;
      default: return 4'b1011;
    endcase
  endfunction

  // balanced, 2-resilient: every mask has weight >= 3
  function automatic logic [TBL_N-1:0] make_filter_table();
    logic [TBL_N-1:0] t;
    logic [SUB_W-1:0] z;
    t = '0;
    for (int n = 0; n < TBL_N; n++) begin
      z    = SUB_W'(n);
      t[n] = (^(z[3:0] & lin_mask(z[6:4]))) ^ (z[6] & z[5]) ^ z[4];
    end
    return t;
  endfunction

endpackage

// File: rtl/kf_select.sv
module kf_select
  import kf_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  input  logic               kind,
  output logic [SEL_W-1:0]   vec
);

  for (genvar i = 0; i < SEL_W; i++) begin : g_tap
    assign vec[i] = (kind == REG_KIND_B) ? state[CELL_MAP_B[i]] : state[CELL_MAP_A[i]];
  end

  logic unused_cells;
  assign unused_cells = ^{state[STATE_W-1:11], state[7]};

endmodule

// File: rtl/kf_gf_inv.sv
module kf_gf_inv
  import kf_pkg::*;
(
  input  logic [SEL_W-1:0] a,
  output logic [SEL_W-1:0] y
);

  // a^(2^9 - 2) = product of a^(2^k), k = 1..8; zero stays zero
  logic [SEL_W-1:0] sq  [0:SEL_W-1];
  logic [SEL_W-1:0] acc [1:SEL_W-1];

  assign sq[0] = a;

  for (genvar k = 1; k < SEL_W; k++) begin : g_sq
    assign sq[k] = gf_mul(sq[k-1], sq[k-1]);
  end

  assign acc[1] = sq[1];

  for (genvar k = 2; k < SEL_W; k++) begin : g_acc
    assign acc[k] = gf_mul(acc[k-1], sq[k]);
  end

  assign y = acc[SEL_W-1];

endmodule

// File: rtl/kf_filter_fn.sv
module kf_filter_fn
  import kf_pkg::*;
(
  input  logic [SUB_W-1:0] idx,
  output logic             bit_out
);

  localparam logic [TBL_N-1:0] FILTER_TBL = make_filter_table();

  assign bit_out = FILTER_TBL[idx];

endmodule

// File: rtl/keyed_filter.sv
module keyed_filter
  import kf_pkg::*;
#(
  parameter int unsigned PIPE = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [STATE_W-1:0] in_state,
  input  logic [KEY_W-1:0]   in_key,
  input  logic               in_type,
  output logic               out_valid,
  output logic               out_jc
);

  localparam int unsigned LAT = 1 + PIPE;

  logic [SEL_W-1:0] sel_vec;
  logic [SEL_W-1:0] sub_in;
  logic [SEL_W-1:0] inv_full;
  logic [SUB_W-1:0] sub_w;
  logic [SUB_W-1:0] idx_d;
  logic [SUB_W-1:0] idx_q;
  logic             vld_q;
  logic             fn_bit;
  logic             jc_d;
  logic             jc_q;
  logic             ov_q;

  kf_select u_sel (
    .state (in_state),
    .kind  (in_type),
    .vec   (sel_vec)
  );

  always_comb begin
    sub_in = sel_vec ^ in_key[SEL_W-1:0];
  end

  kf_gf_inv u_inv (
    .a (sub_in),
    .y (inv_full)
  );

  always_comb begin
    sub_w = inv_full[SUB_W:1];
    idx_d = sub_w ^ in_key[KEY_W-1 -: SUB_W];
  end

  logic unused_inv_ends;
  assign unused_inv_ends = inv_full[0] ^ inv_full[SEL_W-1];

  if (PIPE != 0) begin : g_pipe
    logic [SUB_W-1:0] idx_r;
    logic             vld_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_r <= 1'b0;
        idx_r <= '0;
      end else begin
        vld_r <= in_valid;
        if (in_valid) idx_r <= idx_d;
      end
    end
    assign idx_q = idx_r;
    assign vld_q = vld_r;
  end else begin : g_flat
    assign idx_q = idx_d;
    assign vld_q = in_valid;
  end

  kf_filter_fn u_fn (
    .idx     (idx_q),
    .bit_out (fn_bit)
  );

  always_comb begin
    jc_d = vld_q ? fn_bit : jc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      jc_q <= 1'b0;
    end else begin
      ov_q <= vld_q;
      jc_q <= jc_d;
    end
  end

  assign out_valid = ov_q;
  assign out_jc    = jc_q;

endmodule

// File: rtl/kf_checker.sv
module kf_checker
  import kf_pkg::*;
#(
  parameter int unsigned PIPE = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_jc,
  input logic [SEL_W-1:0] sub_in,
  input logic [SEL_W-1:0] inv_full,
  input logic [SUB_W-1:0] sub_w
);

  localparam int unsigned LAT = 1 + PIPE;

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  if (PIPE != 0) begin : g_lat2
    p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'(LAT)) |-> (out_valid == $past(in_valid, 2)));
  end else begin : g_lat1
    p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'(LAT)) |-> (out_valid == $past(in_valid)));
  end

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_jc));

  p_low_inputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_in <= 9'd2) |-> (sub_w == '0));

  p_inverse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_in != '0) |-> (gf_mul(sub_in, inv_full) == 9'd1));

  p_zero_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_in == '0) |-> (inv_full == '0));

endmodule

bind keyed_filter kf_checker #(.PIPE(PIPE)) u_kf_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_jc    (out_jc),
  .sub_in    (sub_in),
  .inv_full  (inv_full),
  .sub_w     (sub_w)
);

// File: tb/keyed_filter_test.sv
module keyed_filter_test;

  localparam int unsigned PIPE = 1;
  localparam int unsigned LAT  = 2;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [17:0] in_state;
  logic [15:0] in_key;
  logic        in_type;
  logic        out_valid;
  logic        out_jc;

  keyed_filter #(.PIPE(PIPE)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_state  (in_state),
    .in_key    (in_key),
    .in_type   (in_type),
    .out_valid (out_valid),
    .out_jc    (out_jc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic        exp;
    int unsigned due;
    string       tag;
  } item_t;

  item_t sb[$];

  logic [8:0] inv_tab [0:511];

  int unsigned cells_a [0:8] = '{1, 2, 4, 5, 6, 7, 9, 10, 11};
  int unsigned cells_b [0:8] = '{1, 2, 3, 4, 5, 7, 9, 10, 11};

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic logic [8:0] ref_mul(input logic [8:0] a, input logic [8:0] b);
    logic [9:0] aa;
    logic [8:0] r;
    logic [8:0] bb;
    aa = {1'b0, a};
    bb = b;
    r  = '0;
    for (int i = 0; i < 9; i++) begin
      if (bb[0]) r = r ^ aa[8:0];
      bb = bb >> 1;
      aa = aa << 1;
      if (aa[9]) aa = aa ^ 10'h203;
    end
    return r;
  endfunction

  function automatic logic [8:0] ref_vec(input logic [17:0] st, input logic ty);
    logic [8:0] v;
    for (int i = 0; i < 9; i++) v[i] = ty ? st[cells_b[i]-1] : st[cells_a[i]-1];
    return v;
  endfunction

  function automatic logic [17:0] place_vec(input logic [8:0] v, input logic ty,
                                            input logic [17:0] filler);
    logic [17:0] st;
    st = filler;
    for (int i = 0; i < 9; i++) begin
      if (ty) st[cells_b[i]-1] = v[i];
      else    st[cells_a[i]-1] = v[i];
    end
    return st;
  endfunction

  function automatic logic ref_fn(input logic [6:0] z);
    logic [3:0] m;
    case (z[6:4])
      3'd0: m = 4'b0111; 3'd1: m = 4'b1011; 3'd2: m = 4'b1101; 3'd3: m = 4'b1110;
      3'd4: m = 4'b1111; 3'd5: m = 4'b1110; 3'd6: m = 4'b1101; default: m = 4'b1011;
    endcase
    return (^(z[3:0] & m)) ^ (z[6] & z[5]) ^ z[4];
  endfunction

  function automatic logic ref_jc(input logic [17:0] st, input logic [15:0] k, input logic ty);
    logic [8:0] s;
    logic [6:0] w;
    s = ref_vec(st, ty) ^ k[8:0];
    w = inv_tab[s][7:1];
    return ref_fn(w ^ k[15:9]);
  endfunction

  task automatic send(input logic [17:0] st, input logic [15:0] k, input logic ty,
                      input string tag);
    item_t it;
    @(negedge clk);
    in_state = st;
    in_key   = k;
    in_type  = ty;
    in_valid = 1'b1;
    it.exp = ref_jc(st, k, ty);
    it.due = cyc + LAT;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_state = 18'($urandom);
      in_key   = 16'($urandom);
    end
  endtask

  // scoreboard monitor
  logic last_jc = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2 unexpected result", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(out_jc == it.exp, it.tag, int'(out_jc), int'(it.exp));
          chk(cyc == it.due, "R2 arrival cycle", int'(cyc), int'(it.due));
        end
      end else begin
        chk(out_jc == last_jc, "R10 hold while idle", int'(out_jc), int'(last_jc));
      end
      last_jc <= out_jc;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_state = '0;
    in_key   = '0;
    in_type  = 1'b0;

    inv_tab[0] = '0;
    for (int a = 1; a < 512; a++) begin
      for (int b = 1; b < 512; b++) begin
        if (ref_mul(9'(a), 9'(b)) == 9'd1) inv_tab[a] = 9'(b);
      end
    end

    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
      chk(out_jc == 1'b0, "R1 out_jc in reset", int'(out_jc), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R6 / R7: every substitution input, several upper keys, noise in unused cells
    for (int s = 0; s < 512; s++) begin
      for (int kk = 0; kk < 4; kk++) begin
        logic [6:0]  khi;
        logic [8:0]  klo;
        logic        ty;
        logic [17:0] st;
        khi = (kk == 0) ? 7'h00 : (kk == 1) ? 7'h7f : (kk == 2) ? 7'h2a : 7'h55;
        klo = 9'($urandom);
        ty  = 1'((s + kk) & 1);
        st  = place_vec(9'(s) ^ klo, ty, 18'($urandom));
        send(st, {khi, klo}, ty, (s <= 2) ? "R7 low substitution input" : "R6 inverse sweep");
      end
    end

    // R3 / R4: random states per type, gaps between some inputs
    for (int i = 0; i < 400; i++) begin
      logic ty;
      ty = 1'(i & 1);
      send(18'($urandom), 16'($urandom), ty, ty ? "R4 type 1 cells" : "R3 type 0 cells");
      if ((i % 7) == 0) idle(1 + (i % 3));
    end

    // R5: fixed state, low key bits vary
    for (int i = 0; i < 100; i++) begin
      send(18'h2b6d1, {7'h31, 9'($urandom)}, 1'(i & 1), "R5 low key xor");
    end

    // R8: fixed state and low key, high key bits sweep
    for (int i = 0; i < 128; i++) begin
      send(18'h15a3c, {7'(i), 9'h0f3}, 1'(i >> 6), "R8 high key xor");
    end

    // R9: random again, long idle runs
    for (int i = 0; i < 150; i++) begin
      send(18'($urandom), 16'($urandom), 1'($urandom), "R9 output function");
      if ((i % 10) == 0) idle(3);
    end

    // R11: unused cells flipped give the same result
    for (int i = 0; i < 100; i++) begin
      logic [17:0] st;
      logic [17:0] flip;
      logic [15:0] k;
      logic        ty;
      st   = 18'($urandom);
      k    = 16'($urandom);
      ty   = 1'(i & 1);
      flip = 18'($urandom) & (ty ? 18'h3f8a0 : 18'h3f884);
      send(st, k, ty, "R11 unused cells base");
      send(st ^ flip, k, ty, "R11 unused cells flipped");
    end

    idle(LAT + 4);
    chk(sb.size() == 0, "R2 all results delivered", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule